// File: doc/BRIEF.md
# Line Brown-out Supervisor with Zero-Crossing Shutdown

This block supervises the rectified input line of an offline switching controller and produces the run-enable that gates the power switch. It receives two digitised comparator results: one says the line is above the start level and one says it is above the stop level. It also receives a line zero-crossing strobe and the supply reset. After reset the block holds switching off until the line reaches the start level.

A line that stays below the stop level for a full blanking window arms a shutdown. Switching continues until the next zero crossing of the line and stops there. The converter is then at low energy at the moment it stops, and charge left in the input filter cannot lift the sensed line back over the start level. That false restart would otherwise cause visible flicker. If the line recovers to the start level before the zero crossing arrives, the armed shutdown is dropped. A strap input turns supervision off for builds that do not use it. In that case run-enable rises on the first clock after reset and stays high.

Top module: `line_brownout_guard`

## Requirements
- R1: While reset is asserted and on the first sample after its release, run_en and stop_armed are both 0.
- R2: After reset, with supervision on, run_en stays 0 until line_above_start is sampled high on a clock edge. It is 1 from that edge on. line_above_stop alone never raises run_en.
- R3: While running, stop_armed rises on the edge that samples line_above_stop low for the BLANK_CYCLES-th consecutive cycle, and not earlier.
- R4: Any cycle that samples line_above_stop high before the window completes restarts the low-line count from zero.
- R5: While stop_armed is 1, run_en stays 1. The edge that samples zero_cross high drops run_en and stop_armed to 0.
- R6: zero_cross has no effect on run_en while running with no stop armed.
- R7: After a shutdown, run_en stays 0 through zero crossings and through line levels above only the stop level, until line_above_start is sampled high again.
- R8: If line_above_start is sampled high while a stop is armed, the stop is cancelled: run_en stays 1, stop_armed goes to 0, and a fresh full blanking window is needed to arm again.
- R9: When line_above_start and zero_cross are sampled high on the same edge while a stop is armed, the cancel wins and run_en stays 1.
- R10: With supervise_en at 0, run_en is 1 from the first clock after reset whatever the line inputs do, and stop_armed stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Supply reset, active low, asynchronous |
| supervise_en | input | 1 | Strap: 1 enables line supervision, 0 bypasses it |
| line_above_start | input | 1 | Digitised comparator: line above the start level |
| line_above_stop | input | 1 | Digitised comparator: line above the stop level |
| zero_cross | input | 1 | One-cycle strobe at a line zero crossing |
| run_en | output | 1 | Switching permitted |
| stop_armed | output | 1 | Low line confirmed, waiting for a zero crossing to stop |

## Verification
The hardest case to reach is an armed stop that meets a start-level recovery. Three variants matter: the recovery arriving alone, the recovery coinciding with a zero crossing, and a second blanking window that must then start again from zero. Directed sequences build the window exactly. They interrupt it one cycle short, run it to completion, and then apply the recovery and zero-crossing combinations on the cycle after the arm. A long pseudo-random stretch with a rare start level then hits those corners again against the cycle model.

// File: rtl/line_brownout_guard.sv
module line_brownout_guard #(
  parameter int BLANK_CYCLES = 13_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supervise_en,
  input  logic line_above_start,
  input  logic line_above_stop,
  input  logic zero_cross,
  output logic run_en,
  output logic stop_armed
);

  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(BLANK_CYCLES - 1);

  typedef enum logic [1:0] {WAIT_START, RUN, PENDING_STOP} mode_t;

  mode_t mode_q, mode_d;
  logic [CW-1:0] low_cnt_q;
  logic window_done;

  assign window_done = (mode_q == RUN) && !line_above_stop && (low_cnt_q == LAST);

  always_comb begin
    mode_d = mode_q;
    if (!supervise_en) mode_d = RUN;
    else begin
      case (mode_q)
        WAIT_START:   if (line_above_start) mode_d = RUN;
        RUN:          if (window_done) mode_d = PENDING_STOP;
        PENDING_STOP: if (line_above_start) mode_d = RUN;
                      else if (zero_cross) mode_d = WAIT_START;
        default:      mode_d = WAIT_START;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= WAIT_START;
      low_cnt_q <= '0;
    end else begin
      mode_q <= mode_d;
      if (!supervise_en || mode_q != RUN || line_above_stop || window_done)
        low_cnt_q <= '0;
      else
        low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign run_en     = (mode_q != WAIT_START);
  assign stop_armed = (mode_q == PENDING_STOP);

  assert_hold_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (supervise_en && !run_en && !line_above_start) |=> !run_en);

  assert_arm_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_armed) |-> $past(!line_above_stop));

  assert_stop_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (supervise_en && stop_armed && zero_cross && !line_above_start) |=> (!run_en && !stop_armed));

  assert_zero_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !stop_armed) |=> run_en);

  assert_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (supervise_en && stop_armed && line_above_start) |=> (run_en && !stop_armed));

  assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !supervise_en |=> (run_en && !stop_armed));

endmodule

// File: tb/test_line_brownout_guard.sv
module test_line_brownout_guard;
  localparam int B = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supervise_en = 1'b1;
  logic line_above_start = 1'b0;
  logic line_above_stop = 1'b0;
  logic zero_cross = 1'b0;
  logic run_en, stop_armed;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  line_brownout_guard #(.BLANK_CYCLES(B)) i_line_brownout_guard (
    .clk(clk), .rst_n(rst_n), .supervise_en(supervise_en),
    .line_above_start(line_above_start), .line_above_stop(line_above_stop),
    .zero_cross(zero_cross), .run_en(run_en), .stop_armed(stop_armed)
  );

  // reference: 0 = off, 1 = running, 2 = armed
  int m_mode = 0;
  int m_low = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0;
      m_low = 0;
    end else if (!supervise_en) begin
      m_mode = 1;
      m_low = 0;
    end else if (m_mode == 0) begin
      if (line_above_start) m_mode = 1;
      m_low = 0;
    end else if (m_mode == 1) begin
      if (line_above_stop) m_low = 0;
      else begin
        m_low++;
        if (m_low >= B) begin
          m_mode = 2;
          m_low = 0;
        end
      end
    end else begin
      m_low = 0;
      if (line_above_start) m_mode = 1;
      else if (zero_cross) m_mode = 0;
    end
  end

  task automatic expect_bit(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    expect_bit(run_en, (m_mode != 0), cur_req, "model run_en");
    expect_bit(stop_armed, (m_mode == 2), cur_req, "model stop_armed");
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    cyc(3);
    expect_bit(run_en, 1'b0, "R1", "run_en in reset");
    expect_bit(stop_armed, 1'b0, "R1", "stop_armed in reset");
    rst_n = 1'b1;
    cyc(1);
    expect_bit(run_en, 1'b0, "R1", "run_en after release");

    cur_req = "R2";
    line_above_stop = 1'b1;
    cyc(10);
    expect_bit(run_en, 1'b0, "R2", "stop level only");
    line_above_start = 1'b1;
    cyc(1);
    line_above_start = 1'b0;
    expect_bit(run_en, 1'b1, "R2", "start level seen");

    cur_req = "R4";
    line_above_stop = 1'b0;
    cyc(5);
    line_above_stop = 1'b1;
    cyc(1);
    line_above_stop = 1'b0;
    cyc(B - 1);
    expect_bit(stop_armed, 1'b0, "R4", "count restarted");
    cur_req = "R3";
    cyc(1);
    expect_bit(stop_armed, 1'b1, "R3", "window complete");
    expect_bit(run_en, 1'b1, "R5", "still running while armed");

    cur_req = "R5";
    cyc(4);
    expect_bit(run_en, 1'b1, "R5", "waiting for zero crossing");
    zero_cross = 1'b1;
    cyc(1);
    zero_cross = 1'b0;
    expect_bit(run_en, 1'b0, "R5", "stopped at zero crossing");
    expect_bit(stop_armed, 1'b0, "R5", "flag cleared at stop");

    cur_req = "R7";
    line_above_stop = 1'b1;
    for (int i = 0; i < 5; i++) begin
      zero_cross = 1'b1; cyc(1); zero_cross = 1'b0; cyc(1);
    end
    expect_bit(run_en, 1'b0, "R7", "stays off above stop level");
    line_above_start = 1'b1;
    cyc(1);
    line_above_start = 1'b0;
    expect_bit(run_en, 1'b1, "R7", "restart at start level");

    cur_req = "R6";
    for (int i = 0; i < 4; i++) begin
      zero_cross = 1'b1; cyc(1); zero_cross = 1'b0; cyc(1);
    end
    expect_bit(run_en, 1'b1, "R6", "zero crossing ignored");
    expect_bit(stop_armed, 1'b0, "R6", "no flag from zero crossing");

    cur_req = "R8";
    line_above_stop = 1'b0;
    cyc(B);
    expect_bit(stop_armed, 1'b1, "R8", "armed before cancel");
    line_above_start = 1'b1;
    cyc(1);
    line_above_start = 1'b0;
    expect_bit(run_en, 1'b1, "R8", "run kept on cancel");
    expect_bit(stop_armed, 1'b0, "R8", "flag cleared on cancel");
    cyc(B - 1);
    expect_bit(stop_armed, 1'b0, "R8", "fresh window needed");
    cyc(1);
    expect_bit(stop_armed, 1'b1, "R8", "re-armed after full window");

    cur_req = "R9";
    line_above_start = 1'b1;
    zero_cross = 1'b1;
    cyc(1);
    line_above_start = 1'b0;
    zero_cross = 1'b0;
    expect_bit(run_en, 1'b1, "R9", "cancel beats zero crossing");
    expect_bit(stop_armed, 1'b0, "R9", "flag cleared");

    cur_req = "R3";
    for (int i = 0; i < 4000; i++) begin
      line_above_start = ($urandom_range(0, 39) == 0);
      line_above_stop = line_above_start || ($urandom_range(0, 11) == 0);
      zero_cross = ($urandom_range(0, 5) == 0);
      cyc(1);
    end

    cur_req = "R10";
    rst_n = 1'b0;
    supervise_en = 1'b0;
    line_above_start = 1'b0;
    line_above_stop = 1'b0;
    zero_cross = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    expect_bit(run_en, 1'b1, "R10", "bypass run after reset");
    for (int i = 0; i < 300; i++) begin
      line_above_start = $urandom_range(0, 1);
      line_above_stop = $urandom_range(0, 1);
      zero_cross = $urandom_range(0, 1);
      cyc(1);
    end
    expect_bit(run_en, 1'b1, "R10", "bypass holds run");
    expect_bit(stop_armed, 1'b0, "R10", "bypass never arms");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule